// File: doc/BRIEF.md
# Duplex Word Mailbox

This block joins a host processor and a remote agent through two word queues that run in opposite directions. The host sees a small register window on a 32-bit register bus. It pops words that the remote side has queued inbound, it can look at the oldest inbound word without removing it, and it pushes words outbound. The remote agent has plain push and pop ports, each with its own full or empty flag.

Each direction has its own status word, and bits 31 and 30 of that word carry full and empty. A one-bit enable in a configuration register gates a level interrupt. The interrupt is high for as long as inbound words are waiting, and it falls by itself once the host has drained the inbound queue.

Register map, offsets in bytes. Inbound group: 0x00 pop read, 0x10 peek read, 0x18 inbound status, 0x1C configuration. Outbound group: 0x20 push write, 0x38 outbound status. Reads of any other offset return 0, and writes to them have no effect.

Top module: `duplex_mailbox`

## Requirements
- R1: After reset both queues are empty. Offsets 0x18 and 0x38 then read 0x4000_0000, offset 0x1C reads 0, and irq_o is low.
- R2: A bus read of offset 0x00 returns the oldest inbound word in that same cycle and removes it at the clock edge. Words come out in the order the remote side pushed them.
- R3: A bus read of offset 0x10 returns the oldest inbound word without removing it. It returns 0 when the inbound queue is empty.
- R4: Offset 0x18 reads bit 31 = 1 when the inbound queue holds DEPTH (8) words and bit 30 = 1 when it holds none. All other bits read 0.
- R5: Bit 0 of offset 0x1C is a read/write enable. irq_o is high exactly when that bit is 1 and the inbound queue is not empty. Writing 0 drops irq_o on the next cycle.
- R6: A bus write of offset 0x20 appends the write data to the outbound queue. The remote side sees the words on rmt_pop_data_o in write order, and each rmt_pop_i removes one word.
- R7: A bus write of offset 0x20 while the outbound queue is full is discarded, and the stored words are unchanged.
- R8: A read of offset 0x00 while the inbound queue is empty returns 0 and changes no state. A remote push while the inbound queue is full is discarded.
- R9: Offset 0x38 reads bit 31 = 1 when the outbound queue is full and bit 30 = 1 when it is empty. All other bits read 0.
- R10: With the enable set, irq_o falls by itself on the clock edge that removes the last inbound word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset in the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Level interrupt: inbound data waiting |
| rmt_push_i | input | 1 | Remote pushes a word inbound |
| rmt_push_data_i | input | 32 | Word pushed inbound |
| rmt_in_full_o | output | 1 | Inbound queue full |
| rmt_pop_i | input | 1 | Remote removes an outbound word |
| rmt_pop_data_o | output | 32 | Oldest outbound word |
| rmt_out_empty_o | output | 1 | Outbound queue empty |

## Verification
A pointer or count that is off by one shows up at the ports as a word returned out of order, repeated or lost. It appears on the first pop after the fault, and the status bits go wrong once a queue reaches empty or full. A wrong enable or occupancy state shows on irq_o in the very next cycle. The bench therefore compares every popped word against a scoreboard and reads the status words and irq_o at every empty and full boundary in both directions.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_IN_POP   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_IN_PEEK  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_IN_STAT  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_CFG      = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_OUT_PUSH = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_OUT_STAT = 6'h38;

  localparam int unsigned STAT_FULL_BIT  = 31;
  localparam int unsigned STAT_EMPTY_BIT = 30;
  localparam int unsigned CFG_IRQ_EN_BIT = 0;

  function automatic logic [WORD_W-1:0] stat_word(input logic full, input logic empty);
    logic [WORD_W-1:0] w;
    w = '0;
    w[STAT_FULL_BIT]  = full;
    w[STAT_EMPTY_BIT] = empty;
    return w;
  endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW  = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_ptr_q] <= push_data_i;
        wr_ptr_q        <= next_ptr(wr_ptr_q);
      end
      if (do_pop) rd_ptr_q <= next_ptr(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  input  logic [WORD_W-1:0] in_head_i,
  input  logic              in_full_i,
  input  logic              in_empty_i,
  input  logic              out_full_i,
  input  logic              out_empty_i,
  output logic              in_pop_o,
  output logic              out_push_o,
  output logic              irq_o
);
  logic rd_en, wr_en, irq_en_q;

  assign rd_en      = bus_sel_i && !bus_we_i;
  assign wr_en      = bus_sel_i && bus_we_i;
  assign in_pop_o   = rd_en && (bus_addr_i == OFS_IN_POP) && !in_empty_i;
  assign out_push_o = wr_en && (bus_addr_i == OFS_OUT_PUSH);
  assign irq_o      = irq_en_q && !in_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             irq_en_q <= 1'b0;
    else if (wr_en && bus_addr_i == OFS_CFG) irq_en_q <= bus_wdata_i[CFG_IRQ_EN_BIT];
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      unique case (bus_addr_i)
        OFS_IN_POP, OFS_IN_PEEK: bus_rdata_o = in_empty_i ? '0 : in_head_i;
        OFS_IN_STAT:             bus_rdata_o = stat_word(in_full_i, in_empty_i);
        OFS_CFG:                 bus_rdata_o[CFG_IRQ_EN_BIT] = irq_en_q;
        OFS_OUT_STAT:            bus_rdata_o = stat_word(out_full_i, out_empty_i);
        default:                 bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/duplex_mailbox.sv
module duplex_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              irq_o,
  input  logic              rmt_push_i,
  input  logic [WORD_W-1:0] rmt_push_data_i,
  output logic              rmt_in_full_o,
  input  logic              rmt_pop_i,
  output logic [WORD_W-1:0] rmt_pop_data_o,
  output logic              rmt_out_empty_o
);
  logic [WORD_W-1:0] in_head;
  logic              in_full, in_empty, in_pop;
  logic              out_full, out_empty, out_push;
  logic [CW-1:0]     in_cnt, out_cnt;

  mbox_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_in_fifo (
    .clk_i, .rst_ni,
    .push_i(rmt_push_i), .push_data_i(rmt_push_data_i),
    .pop_i(in_pop), .head_o(in_head),
    .full_o(in_full), .empty_o(in_empty), .count_o(in_cnt)
  );

  mbox_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_out_fifo (
    .clk_i, .rst_ni,
    .push_i(out_push), .push_data_i(bus_wdata_i),
    .pop_i(rmt_pop_i), .head_o(rmt_pop_data_o),
    .full_o(out_full), .empty_o(out_empty), .count_o(out_cnt)
  );

  mbox_regs u_regs (
    .clk_i, .rst_ni,
    .bus_sel_i, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .in_head_i(in_head), .in_full_i(in_full), .in_empty_i(in_empty),
    .out_full_i(out_full), .out_empty_i(out_empty),
    .in_pop_o(in_pop), .out_push_o(out_push), .irq_o
  );

  assign rmt_in_full_o   = in_full;
  assign rmt_out_empty_o = out_empty;
endmodule

// File: rtl/duplex_mailbox_chk.sv
module duplex_mailbox_chk
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              irq_o,
  input logic              rmt_push_i,
  input logic              rmt_pop_i,
  input logic [CW-1:0]     in_cnt_i,
  input logic [CW-1:0]     out_cnt_i
);
  logic host_pop_rd, host_push_wr;
  assign host_pop_rd  = bus_sel_i && !bus_we_i && bus_addr_i == OFS_IN_POP;
  assign host_push_wr = bus_sel_i && bus_we_i && bus_addr_i == OFS_OUT_PUSH;

  // R4
  in_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_cnt_i <= CW'(DEPTH));

  // R2
  pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_pop_rd && in_cnt_i != '0 && !rmt_push_i |=> in_cnt_i == $past(in_cnt_i) - 1'b1);

  // R8
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_pop_rd && in_cnt_i == '0 && !rmt_push_i |=> in_cnt_i == '0);

  // R7
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_push_wr && out_cnt_i == CW'(DEPTH) && !rmt_pop_i |=> out_cnt_i == CW'(DEPTH));

  // R5
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_cnt_i == '0 |-> !irq_o);

  // R10
  irq_self_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && in_cnt_i == CW'(1) && host_pop_rd && !rmt_push_i |=> !irq_o);
endmodule

bind duplex_mailbox duplex_mailbox_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .irq_o(irq_o), .rmt_push_i(rmt_push_i), .rmt_pop_i(rmt_pop_i),
  .in_cnt_i(in_cnt), .out_cnt_i(out_cnt)
);

// File: tb/duplex_mailbox_test.sv
module duplex_mailbox_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DEPTH = 8;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        bus_sel_i = 0, bus_we_i = 0;
  logic [5:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0, bus_rdata_o;
  logic        irq_o;
  logic        rmt_push_i = 0, rmt_pop_i = 0;
  logic [31:0] rmt_push_data_i = '0, rmt_pop_data_o;
  logic        rmt_in_full_o, rmt_out_empty_o;

  int compared = 0, mismatched = 0;
  logic [31:0] in_q[$], out_q[$];

  duplex_mailbox #(.DEPTH(DEPTH)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_acc(input logic we, input logic [5:0] addr, input logic [31:0] wd,
                         output logic [31:0] rd);
    @(negedge clk_i);
    bus_sel_i = 1; bus_we_i = we; bus_addr_i = addr; bus_wdata_i = wd;
    #1 rd = bus_rdata_o;
    @(negedge clk_i);
    bus_sel_i = 0; bus_we_i = 0;
  endtask

  task automatic bus_read_chk(input string req, input logic [5:0] addr, input logic [31:0] exp);
    logic [31:0] rd;
    bus_acc(1'b0, addr, '0, rd);
    check(req, rd, exp);
  endtask

  // driver: remote pushes inbound, scoreboard records what must survive
  task automatic remote_push(input logic [31:0] w);
    @(negedge clk_i);
    rmt_push_i = 1; rmt_push_data_i = w;
    if (in_q.size() < DEPTH) in_q.push_back(w);
    @(negedge clk_i);
    rmt_push_i = 0;
  endtask

  // driver: host writes outbound
  task automatic host_push(input logic [31:0] w);
    logic [31:0] rd;
    if (out_q.size() < DEPTH) out_q.push_back(w);
    bus_acc(1'b1, 6'h20, w, rd);
  endtask

  // monitor: host pop compared against scoreboard
  task automatic host_pop_chk(input string req);
    logic [31:0] exp;
    exp = (in_q.size() != 0) ? in_q.pop_front() : 32'h0;
    bus_read_chk(req, 6'h00, exp);
  endtask

  // monitor: remote pop compared against scoreboard
  task automatic remote_pop_chk(input string req);
    logic [31:0] exp;
    @(negedge clk_i);
    #1;
    check({req, " empty flag"}, {31'b0, rmt_out_empty_o}, {31'b0, out_q.size() == 0});
    if (out_q.size() != 0) begin
      exp = out_q.pop_front();
      check(req, rmt_pop_data_o, exp);
    end
    rmt_pop_i = 1;
    @(negedge clk_i);
    rmt_pop_i = 0;
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk_i);
    #1 check(req, {31'b0, irq_o}, {31'b0, exp});
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    bus_read_chk("R1 in stat", 6'h18, 32'h4000_0000);
    bus_read_chk("R1 out stat", 6'h38, 32'h4000_0000);
    bus_read_chk("R1 cfg", 6'h1C, 32'h0);
    irq_chk("R1 irq", 1'b0);

    // R8 empty read, R3 empty peek
    host_pop_chk("R8 empty pop");
    bus_read_chk("R8 stat after empty pop", 6'h18, 32'h4000_0000);
    bus_read_chk("R3 empty peek", 6'h10, 32'h0);

    // R5 irq gated by enable
    remote_push(32'hA000_0001);
    remote_push(32'hA000_0002);
    remote_push(32'hA000_0003);
    irq_chk("R5 irq masked", 1'b0);
    bus_acc(1'b1, 6'h1C, 32'h1, rd);
    bus_read_chk("R5 cfg readback", 6'h1C, 32'h1);
    irq_chk("R5 irq enabled", 1'b1);

    // R3 peek does not pop
    bus_read_chk("R3 peek", 6'h10, 32'hA000_0001);
    bus_read_chk("R3 peek again", 6'h10, 32'hA000_0001);

    // R2 ordered pops, R10 self clear
    host_pop_chk("R2 pop");
    host_pop_chk("R2 pop");
    irq_chk("R10 irq still high", 1'b1);
    host_pop_chk("R2 pop last");
    irq_chk("R10 irq cleared", 1'b0);

    // R4 full boundary, R8 drop on full
    for (int i = 0; i < DEPTH + 1; i++) remote_push(32'hB000_0000 + i);
    bus_read_chk("R4 in full", 6'h18, 32'h8000_0000);
    check("R4 remote full flag", {31'b0, rmt_in_full_o}, 32'h1);
    host_pop_chk("R2 pop after fill");
    bus_read_chk("R4 in mid", 6'h18, 32'h0);
    bus_acc(1'b1, 6'h1C, 32'h0, rd);
    irq_chk("R5 irq disabled with data", 1'b0);
    for (int i = 0; i < DEPTH - 1; i++) host_pop_chk("R8 drain after drop");
    bus_read_chk("R4 in empty again", 6'h18, 32'h4000_0000);

    // R6 outbound order
    host_push(32'hC000_0001);
    host_push(32'hC000_0002);
    bus_read_chk("R9 out mid", 6'h38, 32'h0);
    remote_pop_chk("R6 remote pop");
    remote_pop_chk("R6 remote pop");

    // R7 drop on full, R9 status
    for (int i = 0; i < DEPTH + 1; i++) host_push(32'hD000_0000 + i);
    bus_read_chk("R9 out full", 6'h38, 32'h8000_0000);
    for (int i = 0; i < DEPTH; i++) remote_pop_chk("R7 drain after drop");
    bus_read_chk("R9 out empty", 6'h38, 32'h4000_0000);
    remote_pop_chk("R6 empty flag");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule